// File: doc/BRIEF.md
# Block-transfer host register interface

This block is the host-facing side of a byte-wide block-transfer system interface between a host processor and a management controller. The host sees three byte registers. The control/status register carries the handshake flags and the pointer-reset actions. The data register feeds the inbound message buffer on writes and drains the outbound message buffer on reads. The mask register holds the interrupt enable and the interrupt-pending flag. A level interrupt toward the host is derived from the pending flag.

The host builds a request by clearing the write counter and writing bytes to the data register. It then hands the request over by setting the host-to-controller attention action. That action marks the controller busy and sends a one-cycle event strobe to the backend. The backend reads the inbound bytes through an indexed port. It appends the response bytes to the outbound buffer and signals completion. Completion releases the busy flag, raises controller-to-host attention and, if enabled, makes the interrupt pending. The backend can also set or clear a separate SMS attention flag, and that flag interacts with the interrupt by its own rules.

Top module: `bt_host_regs`

## Requirements
- R1: The host address is masked with WIN-1 (WIN a power of two, default 4). Masked offset 0 selects control, 1 selects data and 2 selects mask, and any other masked offset reads 0xFF. Control reads back bit 3 as controller-to-host attention, bit 4 as SMS attention, bit 6 as host busy and bit 7 as controller busy, with all other bits zero.
- R2: In a control write, a one in bit 3 clears controller-to-host attention, a one in bit 4 clears SMS attention and a one in bit 6 toggles host busy.
- R3: A control write with bit 2 set sets controller busy (control bit 7). It also drives req_event high for exactly the one cycle that follows the write edge.
- R4: A data write stores the byte at the current inbound count only while that count is below DEPTH. The count still increments and saturates at DEPTH+1. A control write with bit 0 set returns the count to zero.
- R5: A data read returns the outbound byte at the read position and advances the position. Reading the last byte returns both the position and the outbound length to zero. A read with nothing pending returns 0xFF. A control write with bit 1 set returns the read position to zero so that the message can be read again.
- R6: be_push appends one byte to the outbound buffer. be_rsp_done clears controller busy, sets controller-to-host attention, and makes the interrupt pending if the enable is set.
- R7: In the mask register, bit 0 is the interrupt enable and bit 1 is interrupt pending. Writing one to bit 1 while the interrupt is pending clears it.
- R8: A mask write that changes the enable from 0 to 1 makes the interrupt pending if either attention flag is set. A change from 1 to 0 clears pending.
- R9: When the backend sets SMS attention, the interrupt becomes pending only if the enable is set and controller-to-host attention is clear. When the backend clears SMS attention, pending is dropped only if controller-to-host attention is clear.
- R10: host_irq is high exactly when interrupt pending and glob_irq_en are both high.
- R11: An active-low rst_n clears the enable, the pending flag, all control flags and all buffer counters.
- R12: If a host control write clears controller-to-host attention in the same cycle as be_rsp_done, the attention stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| host_addr | input | ADDR_W | Host byte address |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data, valid in the cycle host_rd is high |
| glob_irq_en | input | 1 | Global gate for the host interrupt |
| host_irq | output | 1 | Level interrupt toward the host |
| req_event | output | 1 | One-cycle strobe: host handed over a request |
| be_push | input | 1 | Backend appends be_push_byte to the outbound buffer |
| be_push_byte | input | 8 | Outbound byte from the backend |
| be_rsp_done | input | 1 | Backend response complete |
| be_sms_set | input | 1 | Backend sets SMS attention |
| be_sms_clr | input | 1 | Backend clears SMS attention |
| be_in_idx | input | IDX_W | Inbound buffer index read by the backend |
| be_in_byte | output | 8 | Inbound byte at be_in_idx |
| be_in_count | output | CNT_W | Inbound byte count, saturating at DEPTH+1 |

## Verification
The backend completion strobe and a host control write can land on the same clock edge. One of them sets controller-to-host attention and the other clears it. The bench drives be_rsp_done and a control write of 0x08 from the same falling edge. It then reads control and expects bit 3 still set. A second control write of 0x08 on its own must clear the bit, which shows that the write path itself works. The bench also overlaps interrupt-enable writes with SMS attention changes, one cycle at a time, and checks the mask register and host_irq after each step.

// File: rtl/bt_pkg.sv
package bt_pkg;

  // control register bit positions (host software decodes these)
  localparam int unsigned CTL_CLR_WR = 0;
  localparam int unsigned CTL_CLR_RD = 1;
  localparam int unsigned CTL_H2B    = 2;
  localparam int unsigned CTL_B2H    = 3;
  localparam int unsigned CTL_SMS    = 4;
  localparam int unsigned CTL_HBUSY  = 6;
  localparam int unsigned CTL_BBUSY  = 7;

  // mask register bit positions
  localparam int unsigned MSK_EN   = 0;
  localparam int unsigned MSK_PEND = 1;

  localparam logic [7:0] IDLE_BYTE = 8'hFF;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_DATA = 2'd1,
    SEL_MASK = 2'd2,
    SEL_NONE = 2'd3
  } bt_sel_e;

  typedef struct packed {
    logic bbusy;
    logic hbusy;
    logic sms;
    logic b2h;
  } bt_flags_t;

  function automatic bt_sel_e bt_decode(input int unsigned off);
    case (off)
      0:       return SEL_CTRL;
      1:       return SEL_DATA;
      2:       return SEL_MASK;
      default: return SEL_NONE;
    endcase
  endfunction

  function automatic int unsigned bt_sat_inc(input int unsigned val,
                                             input int unsigned lim);
    return (val >= lim) ? lim : val + 1;
  endfunction

  function automatic logic [7:0] bt_ctrl_image(input bt_flags_t f);
    logic [7:0] img;
    img             = 8'h00;
    img[CTL_B2H]    = f.b2h;
    img[CTL_SMS]    = f.sms;
    img[CTL_HBUSY]  = f.hbusy;
    img[CTL_BBUSY]  = f.bbusy;
    return img;
  endfunction

endpackage

// File: rtl/bt_inbound.sv
module bt_inbound #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned IDX_W = $clog2(DEPTH),
  parameter int unsigned CNT_W = $clog2(DEPTH + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_byte,
  input  logic             clr,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_byte,
  output logic [CNT_W-1:0] count
);
  import bt_pkg::*;

  logic [7:0] mem [DEPTH];
  logic       store;

  assign store   = wr_en && !clr && (32'(count) < DEPTH);
  assign rd_byte = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (store) mem[count[IDX_W-1:0]] <= wr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clr)   count <= '0;
    else if (wr_en) count <= CNT_W'(bt_sat_inc(32'(count), DEPTH + 1));
  end
endmodule

// File: rtl/bt_outbound.sv
module bt_outbound #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned IDX_W = $clog2(DEPTH),
  parameter int unsigned CNT_W = $clog2(DEPTH + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [7:0]       push_byte,
  input  logic             rd_req,
  input  logic             clr_pos,
  output logic [7:0]       rd_byte,
  output logic [CNT_W-1:0] pos,
  output logic [CNT_W-1:0] len
);
  import bt_pkg::*;

  logic [7:0] mem [DEPTH];
  logic       avail;
  logic       rd_hit;
  logic       rd_last;
  logic       do_push;

  assign avail   = (pos < len);
  assign rd_hit  = rd_req && avail;
  assign rd_last = rd_hit && (32'(pos) + 1 == 32'(len));
  assign do_push = push && !rd_last && (32'(len) < DEPTH);
  assign rd_byte = avail ? mem[pos[IDX_W-1:0]] : IDLE_BYTE;

  always_ff @(posedge clk) begin
    if (do_push) mem[len[IDX_W-1:0]] <= push_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
      len <= '0;
    end else if (rd_last) begin
      pos <= '0;
      len <= '0;
    end else begin
      if (clr_pos)     pos <= '0;
      else if (rd_hit) pos <= pos + 1'b1;
      if (do_push)     len <= len + 1'b1;
    end
  end
endmodule

// File: rtl/bt_irq_ctrl.sv
module bt_irq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mask_wr,
  input  logic [1:0] mask_wdata,
  input  logic       b2h_now,
  input  logic       sms_now,
  input  logic       rsp_done,
  input  logic       sms_set_evt,
  input  logic       sms_clr_evt,
  output logic       en,
  output logic       pend
);
  import bt_pkg::*;

  logic en_n;
  logic pend_n;

  always_comb begin
    en_n   = en;
    pend_n = pend;
    if (mask_wr) begin
      if (mask_wdata[MSK_EN] != en) begin
        if (mask_wdata[MSK_EN]) begin
          if (b2h_now || sms_now) pend_n = 1'b1;
          en_n = 1'b1;
        end else begin
          pend_n = 1'b0;
          en_n   = 1'b0;
        end
      end
      if (mask_wdata[MSK_PEND] && pend_n) pend_n = 1'b0;
    end
    if (rsp_done && en_n) pend_n = 1'b1;
    if (sms_set_evt && !b2h_now && en_n) pend_n = 1'b1;
    if (sms_clr_evt && !b2h_now && !rsp_done) pend_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      pend <= 1'b0;
    end else begin
      en   <= en_n;
      pend <= pend_n;
    end
  end
endmodule

// File: rtl/bt_host_regs.sv
module bt_host_regs #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned WIN    = 4,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              glob_irq_en,
  output logic              host_irq,
  output logic              req_event,
  input  logic              be_push,
  input  logic [7:0]        be_push_byte,
  input  logic              be_rsp_done,
  input  logic              be_sms_set,
  input  logic              be_sms_clr,
  input  logic [IDX_W-1:0]  be_in_idx,
  output logic [7:0]        be_in_byte,
  output logic [CNT_W-1:0]  be_in_count
);
  import bt_pkg::*;

  // decode
  logic [ADDR_W-1:0] off_masked;
  bt_sel_e           sel;
  logic              ctrl_wr, data_wr, mask_wr, data_rd;

  assign off_masked = host_addr & ADDR_W'(WIN - 1);
  assign sel        = bt_decode(32'(off_masked));
  assign ctrl_wr    = host_wr && (sel == SEL_CTRL);
  assign data_wr    = host_wr && (sel == SEL_DATA);
  assign mask_wr    = host_wr && (sel == SEL_MASK);
  assign data_rd    = host_rd && (sel == SEL_DATA);

  // named internal events
  bt_flags_t flags_q, flags_n;
  logic      h2b_req;
  logic      sms_set_evt, sms_clr_evt;
  logic      req_q;

  assign h2b_req     = ctrl_wr && host_wdata[CTL_H2B];
  assign sms_set_evt = be_sms_set && !flags_q.sms;
  assign sms_clr_evt = be_sms_clr && !be_sms_set && flags_q.sms;

  always_comb begin
    flags_n = flags_q;
    if (ctrl_wr && host_wdata[CTL_B2H])   flags_n.b2h   = 1'b0;
    if (ctrl_wr && host_wdata[CTL_SMS])   flags_n.sms   = 1'b0;
    if (ctrl_wr && host_wdata[CTL_HBUSY]) flags_n.hbusy = !flags_q.hbusy;
    if (be_rsp_done)                      flags_n.b2h   = 1'b1;
    if (be_rsp_done)                      flags_n.bbusy = 1'b0;
    if (h2b_req)                          flags_n.bbusy = 1'b1;
    if (sms_set_evt)                      flags_n.sms   = 1'b1;
    else if (sms_clr_evt)                 flags_n.sms   = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      req_q   <= 1'b0;
    end else begin
      flags_q <= flags_n;
      req_q   <= h2b_req;
    end
  end

  assign req_event = req_q;

  // inbound buffer
  bt_inbound #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_in (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (data_wr),
    .wr_byte (host_wdata),
    .clr     (ctrl_wr && host_wdata[CTL_CLR_WR]),
    .rd_idx  (be_in_idx),
    .rd_byte (be_in_byte),
    .count   (be_in_count)
  );

  // outbound buffer
  logic [7:0]       out_byte;
  logic [CNT_W-1:0] out_pos, out_len;

  bt_outbound #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (be_push),
    .push_byte (be_push_byte),
    .rd_req    (data_rd),
    .clr_pos   (ctrl_wr && host_wdata[CTL_CLR_RD]),
    .rd_byte   (out_byte),
    .pos       (out_pos),
    .len       (out_len)
  );

  // interrupt
  logic irq_en, irq_pend;

  bt_irq_ctrl u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .mask_wr     (mask_wr),
    .mask_wdata  (host_wdata[1:0]),
    .b2h_now     (flags_q.b2h),
    .sms_now     (flags_q.sms),
    .rsp_done    (be_rsp_done),
    .sms_set_evt (sms_set_evt),
    .sms_clr_evt (sms_clr_evt),
    .en          (irq_en),
    .pend        (irq_pend)
  );

  assign host_irq = irq_pend && glob_irq_en;

  // read mux
  always_comb begin
    case (sel)
      SEL_CTRL: host_rdata = bt_ctrl_image(flags_q);
      SEL_DATA: host_rdata = out_byte;
      SEL_MASK: host_rdata = {6'b0, irq_pend, irq_en};
      default:  host_rdata = IDLE_BYTE;
    endcase
  end

  logic unused_wbits;
  assign unused_wbits = ^{host_wdata[5], host_wdata[7:2]};
endmodule

// File: rtl/bt_host_regs_chk.sv
module bt_host_regs_chk #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_event,
  input logic             bbusy,
  input logic [CNT_W-1:0] in_count,
  input logic [CNT_W-1:0] out_pos,
  input logic [CNT_W-1:0] out_len,
  input logic             mask_wr,
  input logic [1:0]       mask_wdata,
  input logic             en,
  input logic             pend,
  input logic             rsp_done,
  input logic             sms_set_evt,
  input logic             host_irq
);
  AST_REQ_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_event |-> bbusy); // R3

  AST_IN_COUNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    32'(in_count) <= DEPTH + 1); // R4

  AST_OUT_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_pos <= out_len); // R5

  AST_DONE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && en && !mask_wr) |=> pend); // R6

  AST_PEND_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && mask_wdata[1] && (mask_wdata[0] == en) && !rsp_done && !sms_set_evt)
      |=> !pend); // R7

  AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && !mask_wdata[0] && en) |=> (!pend && !en)); // R8

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> pend); // R10
endmodule

bind bt_host_regs bt_host_regs_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_event   (req_event),
  .bbusy       (flags_q.bbusy),
  .in_count    (be_in_count),
  .out_pos     (out_pos),
  .out_len     (out_len),
  .mask_wr     (mask_wr),
  .mask_wdata  (host_wdata[1:0]),
  .en          (irq_en),
  .pend        (irq_pend),
  .rsp_done    (be_rsp_done),
  .sms_set_evt (sms_set_evt),
  .host_irq    (host_irq)
);

// File: tb/test_bt_host_regs.sv
`timescale 1ns/1ps
module test_bt_host_regs;
  localparam int DEPTH = 64;
  localparam int NVEC  = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] host_addr = '0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       glob_irq_en = 1'b1;
  logic       host_irq, req_event;
  logic       be_push = 1'b0;
  logic [7:0] be_push_byte = '0;
  logic       be_rsp_done = 1'b0, be_sms_set = 1'b0, be_sms_clr = 1'b0;
  logic [5:0] be_in_idx = '0;
  logic [7:0] be_in_byte;
  logic [6:0] be_in_count;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bt_host_regs i_bt_host_regs (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .glob_irq_en(glob_irq_en), .host_irq(host_irq), .req_event(req_event),
    .be_push(be_push), .be_push_byte(be_push_byte), .be_rsp_done(be_rsp_done),
    .be_sms_set(be_sms_set), .be_sms_clr(be_sms_clr), .be_in_idx(be_in_idx),
    .be_in_byte(be_in_byte), .be_in_count(be_in_count)
  );

  // {op, addr, wdata, expected}; op 0 = write, 1 = read and compare
  localparam logic [25:0] VEC [NVEC] = '{
    {2'd1, 8'h00, 8'h00, 8'h00},
    {2'd1, 8'h03, 8'h00, 8'hFF},
    {2'd1, 8'h01, 8'h00, 8'hFF},
    {2'd0, 8'h00, 8'h40, 8'h00},
    {2'd1, 8'h00, 8'h00, 8'h40},
    {2'd1, 8'h04, 8'h00, 8'h40},
    {2'd0, 8'h00, 8'h40, 8'h00},
    {2'd1, 8'h00, 8'h00, 8'h00},
    {2'd1, 8'h06, 8'h00, 8'h00},
    {2'd1, 8'h07, 8'h00, 8'hFF}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    logic [7:0] d;
    host_read(a, d);
    chk(d === e, tag, d, e);
  endtask

  task automatic pulse_push(input logic [7:0] b);
    @(negedge clk);
    be_push = 1'b1; be_push_byte = b;
    @(negedge clk);
    be_push = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); be_rsp_done = 1'b1;
    @(negedge clk); be_rsp_done = 1'b0;
  endtask

  task automatic pulse_sms(input bit set);
    @(negedge clk);
    if (set) be_sms_set = 1'b1; else be_sms_clr = 1'b1;
    @(negedge clk);
    be_sms_set = 1'b0; be_sms_clr = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(host_irq === 1'b0 && req_event === 1'b0, "R11 reset outputs", host_irq, 0);
    chk(be_in_count === 7'd0, "R11 reset inbound count", be_in_count, 0);

    // table walk: decode, aliasing, host busy toggle
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] d;
      if (VEC[i][25:24] == 2'd0) host_write(VEC[i][23:16], VEC[i][15:8]);
      else begin
        host_read(VEC[i][23:16], d);
        chk(d === VEC[i][7:0], $sformatf("R1/R2/R5 vector %0d", i), d, VEC[i][7:0]);
      end
    end

    // R3 request handover
    host_write(8'h00, 8'h04);
    chk(req_event === 1'b1, "R3 event high after write", req_event, 1);
    @(negedge clk);
    chk(req_event === 1'b0, "R3 event one cycle", req_event, 0);
    expect_rd(8'h00, 8'h80, "R3 controller busy");

    // R4 inbound buffer
    host_write(8'h00, 8'h01);
    host_write(8'h01, 8'hAA);
    host_write(8'h01, 8'hBB);
    host_write(8'h01, 8'hCC);
    chk(be_in_count === 7'd3, "R4 count three", be_in_count, 3);
    be_in_idx = 6'd1; #1;
    chk(be_in_byte === 8'hBB, "R4 stored byte", be_in_byte, 8'hBB);
    host_write(8'h00, 8'h01);
    chk(be_in_count === 7'd0, "R4 clear count", be_in_count, 0);
    for (int i = 0; i < DEPTH + 3; i++) host_write(8'h01, 8'(i + 16));
    chk(be_in_count === 7'(DEPTH + 1), "R4 count saturates", be_in_count, DEPTH + 1);
    be_in_idx = 6'(DEPTH - 1); #1;
    chk(be_in_byte === 8'(DEPTH - 1 + 16), "R4 last stored byte kept", be_in_byte, DEPTH - 1 + 16);
    be_in_idx = 6'd0; #1;
    chk(be_in_byte === 8'h10, "R4 first byte kept", be_in_byte, 8'h10);

    // R6 / R5 outbound
    pulse_push(8'h11); pulse_push(8'h22); pulse_push(8'h33);
    pulse_done();
    expect_rd(8'h00, 8'h08, "R6 done: attention set, busy clear");
    expect_rd(8'h02, 8'h00, "R6 no pend while disabled");
    expect_rd(8'h01, 8'h11, "R5 byte 0");
    expect_rd(8'h01, 8'h22, "R5 byte 1");
    expect_rd(8'h01, 8'h33, "R5 byte 2");
    expect_rd(8'h01, 8'hFF, "R5 drained");
    pulse_push(8'h44); pulse_push(8'h55);
    expect_rd(8'h01, 8'h44, "R5 first read");
    host_write(8'h00, 8'h02);
    expect_rd(8'h01, 8'h44, "R5 reread after clear");
    expect_rd(8'h01, 8'h55, "R5 second byte");
    expect_rd(8'h01, 8'hFF, "R5 empty again");

    // R7 R8 R10 interrupt (attention still set)
    host_write(8'h02, 8'h01);
    expect_rd(8'h02, 8'h03, "R8 enable with attention pends");
    chk(host_irq === 1'b1, "R10 irq high", host_irq, 1);
    glob_irq_en = 1'b0; #1;
    chk(host_irq === 1'b0, "R10 gated off", host_irq, 0);
    glob_irq_en = 1'b1;
    host_write(8'h02, 8'h03);
    expect_rd(8'h02, 8'h01, "R7 pending cleared");
    chk(host_irq === 1'b0, "R7 irq dropped", host_irq, 0);
    host_write(8'h02, 8'h02);
    expect_rd(8'h02, 8'h00, "R8 disable");
    host_write(8'h02, 8'h01);
    expect_rd(8'h02, 8'h03, "R8 re-enable pends");
    host_write(8'h02, 8'h00);
    expect_rd(8'h02, 8'h00, "R8 disable clears pending");

    // R9 SMS attention
    host_write(8'h00, 8'h08);
    expect_rd(8'h00, 8'h00, "R2 attention cleared");
    host_write(8'h02, 8'h01);
    expect_rd(8'h02, 8'h01, "R8 enable without attention");
    pulse_sms(1'b1);
    expect_rd(8'h00, 8'h10, "R9 sms flag set");
    expect_rd(8'h02, 8'h03, "R9 sms pends");
    pulse_sms(1'b0);
    expect_rd(8'h02, 8'h01, "R9 sms clear drops pending");
    pulse_done();
    expect_rd(8'h02, 8'h03, "R6 done pends when enabled");
    host_write(8'h02, 8'h03);
    pulse_sms(1'b1);
    expect_rd(8'h00, 8'h18, "R9 both attentions");
    expect_rd(8'h02, 8'h01, "R9 sms set blocked by attention");
    host_write(8'h02, 8'h00);
    host_write(8'h02, 8'h01);
    pulse_sms(1'b0);
    expect_rd(8'h02, 8'h03, "R9 sms clear keeps pending");
    pulse_sms(1'b1);
    host_write(8'h00, 8'h10);
    expect_rd(8'h00, 8'h08, "R2 sms write-one clear");

    // R12 collision
    @(negedge clk);
    host_addr = 8'h00; host_wdata = 8'h08; host_wr = 1'b1; be_rsp_done = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; be_rsp_done = 1'b0;
    expect_rd(8'h00, 8'h08, "R12 completion wins");
    host_write(8'h00, 8'h08);
    expect_rd(8'h00, 8'h00, "R12 plain clear works");

    // R11 cold reset
    pulse_done();
    expect_rd(8'h02, 8'h03, "R11 pending before reset");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    expect_rd(8'h02, 8'h00, "R11 mask cleared");
    expect_rd(8'h00, 8'h00, "R11 control cleared");
    chk(host_irq === 1'b0, "R11 irq low", host_irq, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule